// File: doc/BRIEF.md
# Mode-Selectable 8b/10b Serial Transmit Path

This block turns parallel transmit words for one channel into a serial bit stream running at one bit per clock. A word enters as two 5-bit halves on a half-width bus. The block drives a word clock that runs at one tenth of the bit clock. The lower half of the word is taken on the falling edge of that word clock. The upper half, the control-request bit and the mode inputs are taken on its rising edge. Sampling on both edges lets the host move a 10-bit word over a 5-bit bus in each word period.

Encoding is switched on when the mode pin or the management enable bit is high. With encoding off, the 10 bits pass straight through as a pre-coded group. With encoding on, the low 8 bits are mapped to an 8b/10b group under running disparity. When the control-request bit is set, the block emits a special code group. Whichever group results is loaded into a shifter at the rising edge of the word clock. It is then sent out least significant bit first during the next word period. A request for an undefined special code sends the comma group K28.5 and raises a sticky error flag.

Top module: `tx_8b10b_serializer`

## Requirements
- R1: While reset is low, and in the first cycle after it, `ser_out` is 0, `word_clk` is 1 and `k_err` is 0.
- R2: `word_clk` is high for 5 bit-clock cycles and then low for 5, starting in the high phase after reset.
- R3: `tx_half` is sampled as word bits 4:0 at the clock edge where `word_clk` falls, and as word bits 9:5 at the edge where it rises. `tx_k`, `mode_pin` and `mode_reg_en` are also sampled at the rising edge. The resulting group is loaded at that same edge.
- R4: A loaded group appears on `ser_out` in the 10 cycles that follow the load, bit 0 first, one bit per cycle.
- R5: Encoding is active when `mode_pin` or `mode_reg_en` is 1. Either input alone is enough.
- R6: With encoding off, the 10-bit word is sent unchanged, `tx_k` has no effect, `k_err` does not change, and the running disparity is kept for the next encoded group.
- R7: With encoding on and `tx_k` low, word bits 7:0 (EDCBA = bits 4:0, HGF = bits 7:5) are sent as an 8b/10b group. Code bits a..i go in group bits 0..5 and f..j in bits 6..9. Each 6-bit sub-block has 2 to 4 ones, each 4-bit sub-block has 1 to 3 ones, and the encoded stream never has a run longer than 5. D0.0 is a..j 1001110100 at negative disparity and 0110001011 at positive disparity. D21.5 is 1010101010.
- R8: Running disparity is negative after reset. A group sent at negative disparity has 5 or 6 ones, and one sent at positive disparity has 4 or 5. A group with 6 ones makes the disparity positive, 4 ones makes it negative, and 5 ones leaves it unchanged.
- R9: With encoding on and `tx_k` high, the bytes 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD and 0xFE produce their special groups and leave `k_err` low. K28.5 (0xBC) is a..j 0011111010 at negative disparity and 1100000101 at positive disparity.
- R10: With encoding on, a special request for any other byte sends K28.5 at the current disparity and sets `k_err`, which stays 1 until reset.
- R11: Values on `mode_pin`, `mode_reg_en` and `tx_k` while `word_clk` is high have no effect. The mode of each group is fixed at its load.
- R12: The 256 data bytes map to distinct groups, and no data group equals a special group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pin | input | 1 | Encode enable, pin source |
| mode_reg_en | input | 1 | Encode enable, management register source |
| tx_half | input | 5 | Half of the transmit word, lower half then upper half |
| tx_k | input | 1 | Special-character request |
| word_clk | output | 1 | Word clock, bit clock divided by 10 |
| ser_out | output | 1 | Serial data, bit 0 of each group first |
| k_err | output | 1 | Sticky flag for an undefined special request |

## Verification
A wrong phase or a stuck half counter in the word sequencer shows up in `word_clk` within one word period. It also shifts every later group by whole bits, so the first bypass comparison fails. A corrupted disparity register does not show until the next encoded group with an unequal ones count. That group then breaks the ones-count rule of R8, and the bench checks this on every group of the full byte sweeps, which follow bypass words so that a disparity that bypass should preserve is exercised too. Table errors in the encoder show as duplicate groups, sub-block counts out of range or overlong runs, usually within one sweep of the 256 bytes.

// File: rtl/tx8b10b_pkg.sv
package tx8b10b_pkg;

    localparam int GRP_W      = 10;
    localparam int HALF_W     = GRP_W / 2;
    localparam int BYTE_W     = 8;
    localparam int HALF_CNT_W = $clog2(HALF_W);

    typedef enum logic [0:0] {
        PH_FIRST  = 1'b0,   // word clock high, lower half being presented
        PH_SECOND = 1'b1    // word clock low, upper half being presented
    } phase_e;

    // 6-bit sub-block for negative disparity, written a..i with a as MSB.
    function automatic logic [5:0] six_neg(input logic [4:0] x);
        logic [5:0] r;
        unique case (x)
            5'd0:  r = 6'b100111;
            5'd1:  r = 6'b011101;
            5'd2:  r = 6'b101101;
            5'd3:  r = 6'b110001;
            5'd4:  r = 6'b110101;
            5'd5:  r = 6'b101001;
            5'd6:  r = 6'b011001;
            5'd7:  r = 6'b111000;
            5'd8:  r = 6'b111001;
            5'd9:  r = 6'b100101;
            5'd10: r = 6'b010101;
            5'd11: r = 6'b110100;
            5'd12: r = 6'b001101;
            5'd13: r = 6'b101100;
            5'd14: r = 6'b011100;
            5'd15: r = 6'b010111;
            5'd16: r = 6'b011011;
            5'd17: r = 6'b100011;
            5'd18: r = 6'b010011;
            5'd19: r = 6'b110010;
            5'd20: r = 6'b001011;
            5'd21: r = 6'b101010;
            5'd22: r = 6'b011010;
            5'd23: r = 6'b111010;
            5'd24: r = 6'b110011;
            5'd25: r = 6'b100110;
            5'd26: r = 6'b010110;
            5'd27: r = 6'b110110;
            5'd28: r = 6'b001110;
            5'd29: r = 6'b101110;
            5'd30: r = 6'b011110;
            default: r = 6'b101011;
        endcase
        return r;
    endfunction

    // 4-bit sub-block when the disparity after the 6-bit part is negative, f..j with f as MSB.
    function automatic logic [3:0] four_neg(input logic [2:0] y);
        logic [3:0] r;
        unique case (y)
            3'd0: r = 4'b1011;
            3'd1: r = 4'b1001;
            3'd2: r = 4'b0101;
            3'd3: r = 4'b1100;
            3'd4: r = 4'b1101;
            3'd5: r = 4'b1010;
            3'd6: r = 4'b0110;
            default: r = 4'b1110;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tx_word_seq.sv
module tx_word_seq
    import tx8b10b_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic word_clk,
    output logic cap_lo,
    output logic load
);

    localparam logic [HALF_CNT_W-1:0] HALF_LAST = HALF_CNT_W'(HALF_W - 1);

    phase_e                state_q, state_d;
    logic [HALF_CNT_W-1:0] half_q, half_d;
    logic                  half_end;

    assign half_end = (half_q == HALF_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_FIRST;
            half_q  <= '0;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        half_d  = half_end ? '0 : half_q + 1'b1;
        unique case (state_q)
            PH_FIRST:  if (half_end) state_d = PH_SECOND;
            PH_SECOND: if (half_end) state_d = PH_FIRST;
            default:   state_d = PH_FIRST;
        endcase
    end

    // outputs
    always_comb begin
        word_clk = 1'b0;
        cap_lo   = 1'b0;
        load     = 1'b0;
        unique case (state_q)
            PH_FIRST: begin
                word_clk = 1'b1;
                cap_lo   = half_end;
            end
            PH_SECOND: begin
                load = half_end;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/enc_8b10b.sv
module enc_8b10b
    import tx8b10b_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    input  logic              is_k,
    input  logic              rd_in,     // 1 = positive
    output logic [GRP_W-1:0]  code,      // bit 0 = a, sent first
    output logic              rd_out,
    output logic              k_bad
);

    logic [4:0] x, use_x;
    logic [2:0] y, use_y;
    logic       k_valid, k28;
    logic [5:0] s6n, s6;
    logic [3:0] f4n, s4;
    logic       unbal6, flip6, rd6, alt7, comp_y, flip4;

    assign x = din[4:0];
    assign y = din[7:5];

    always_comb begin
        k_valid = is_k && ((x == 5'd28) ||
                  ((y == 3'd7) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30)));
        k_bad   = is_k && !k_valid;
        use_x   = k_bad ? 5'd28 : x;
        use_y   = k_bad ? 3'd5  : y;
        k28     = is_k && (use_x == 5'd28);

        // 5b/6b sub-block
        s6n    = k28 ? 6'b001111 : six_neg(use_x);
        unbal6 = ($countones(s6n) != 3);
        flip6  = rd_in && (unbal6 || (use_x == 5'd7 && !k28));
        s6     = flip6 ? ~s6n : s6n;
        rd6    = unbal6 ? ~rd_in : rd_in;

        // 3b/4b sub-block
        alt7   = (use_y == 3'd7) &&
                 (is_k ||
                  (!rd6 && (use_x == 5'd17 || use_x == 5'd18 || use_x == 5'd20)) ||
                  ( rd6 && (use_x == 5'd11 || use_x == 5'd13 || use_x == 5'd14)));
        f4n    = alt7 ? 4'b0111 : four_neg(use_y);
        comp_y = (use_y == 3'd0 || use_y == 3'd3 || use_y == 3'd4 || use_y == 3'd7);
        flip4  = k28 ? (rd6 ? comp_y : !comp_y) : (rd6 && comp_y);
        s4     = flip4 ? ~f4n : f4n;

        if ($countones(s4) == 2) rd_out = rd6;
        else                     rd_out = ($countones(s4) > 2);

        code = {s4[0], s4[1], s4[2], s4[3], s6[0], s6[1], s6[2], s6[3], s6[4], s6[5]};
    end

endmodule

// File: rtl/tx_shift.sv
module tx_shift
    import tx8b10b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GRP_W-1:0] din,
    output logic [GRP_W-1:0] q,
    output logic             sout
);

    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
        else           q <= {1'b0, q[GRP_W-1:1]};
    end

    assign sout = q[0];

endmodule

// File: rtl/tx_8b10b_serializer.sv
module tx_8b10b_serializer
    import tx8b10b_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pin,
    input  logic              mode_reg_en,
    input  logic [HALF_W-1:0] tx_half,
    input  logic              tx_k,
    output logic              word_clk,
    output logic              ser_out,
    output logic              k_err
);

    logic              cap_lo, load_w;
    logic [HALF_W-1:0] lo_q;
    logic [GRP_W-1:0]  word_in, code, load_val, sh_q;
    logic              enc_en, rd_q, rd_next, k_bad, kerr_q;

    tx_word_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_clk (word_clk),
        .cap_lo   (cap_lo),
        .load     (load_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      lo_q <= '0;
        else if (cap_lo) lo_q <= tx_half;
    end

    assign word_in = {tx_half, lo_q};
    assign enc_en  = mode_pin | mode_reg_en;

    enc_8b10b enc_i (
        .din    (word_in[BYTE_W-1:0]),
        .is_k   (tx_k),
        .rd_in  (rd_q),
        .code   (code),
        .rd_out (rd_next),
        .k_bad  (k_bad)
    );

    assign load_val = enc_en ? code : word_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            kerr_q <= 1'b0;
        end else if (load_w && enc_en) begin
            rd_q   <= rd_next;
            kerr_q <= kerr_q | k_bad;
        end
    end

    assign k_err = kerr_q;

    tx_shift sh_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_w),
        .din   (load_val),
        .q     (sh_q),
        .sout  (ser_out)
    );

endmodule

// File: rtl/tx_8b10b_serializer_chk.sv
module tx_8b10b_serializer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       word_clk,
    input logic       ser_out,
    input logic       k_err,
    input logic       load,
    input logic       enc_en,
    input logic       rd_q,
    input logic [9:0] shreg
);

    a_r2_word_clk_shape: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_clk) |-> (!$past(word_clk, 1) && !$past(word_clk, 5) && $past(word_clk, 6)));

    a_r3_load_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> $rose(word_clk));

    a_r4_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (ser_out == $past(shreg[1])));

    a_r6_bypass_keeps_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !enc_en) |=> $stable(rd_q));

    a_r7_group_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (load && enc_en) |=> ($countones(shreg) >= 4 && $countones(shreg) <= 6));

    a_r8_neg_rd_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (load && enc_en && !rd_q) |=> ($countones(shreg) >= 5));

    a_r8_pos_rd_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (load && enc_en && rd_q) |=> ($countones(shreg) <= 5));

    a_r10_kerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        k_err |=> k_err);

    a_r10_kerr_at_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(k_err) |-> $past(load && enc_en));

endmodule

bind tx_8b10b_serializer tx_8b10b_serializer_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_clk (word_clk),
    .ser_out  (ser_out),
    .k_err    (k_err),
    .load     (load_w),
    .enc_en   (enc_en),
    .rd_q     (rd_q),
    .shreg    (sh_q)
);

// File: tb/tx_8b10b_serializer_tb_top.sv
`timescale 1ns/1ps
module tx_8b10b_serializer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_pin = 1'b0;
    logic       mode_reg_en = 1'b0;
    logic [4:0] tx_half = '0;
    logic       tx_k = 1'b0;
    logic       word_clk, ser_out, k_err;

    always #2 clk = ~clk;

    tx_8b10b_serializer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_pin    (mode_pin),
        .mode_reg_en (mode_reg_en),
        .tx_half     (tx_half),
        .tx_k        (tx_k),
        .word_clk    (word_clk),
        .ser_out     (ser_out),
        .k_err       (k_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model state
    bit         rd = 1'b0;
    bit         exp_kerr = 1'b0;
    int         owner [1024];
    bit         run_bit = 1'b0;
    int         run_len = 0;
    bit         last_valid = 1'b0;
    logic [9:0] last_w = '0;
    bit         last_k = 1'b0;
    bit         last_en = 1'b0;
    string      last_req = "";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] lit(input logic [9:0] a2j);
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = a2j[9-i];
        return r;
    endfunction

    function automatic bit k_ok(input logic [7:0] b);
        return b inside {8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
                         8'hF7, 8'hFB, 8'hFD, 8'hFE};
    endfunction

    // One word period starting at a falling clock edge; returns the group sent meanwhile.
    task automatic xfer(input logic [9:0] w, input bit k, input bit pin, input bit regb,
                        input bit glitch, output logic [9:0] g);
        bit wc_ok = 1'b1;
        for (int j = 0; j < 10; j++) begin
            g[j] = ser_out;
            if (word_clk !== (j < 5)) wc_ok = 1'b0;
            if (j < 5) begin
                tx_half = w[4:0];
                if (glitch) begin
                    tx_k        = ~k;
                    mode_pin    = !(pin | regb);
                    mode_reg_en = 1'b0;
                end
            end else begin
                tx_half     = w[9:5];
                tx_k        = k;
                mode_pin    = pin;
                mode_reg_en = regb;
            end
            @(negedge clk);
        end
        chk(wc_ok, "R2", "word_clk phase pattern", 0, 0);
    endtask

    task automatic eval_prev(input logic [9:0] g);
        int ones, o6, o4, maxr, key;
        logic [9:0] exp_g;
        if (!last_valid) return;
        if (!last_en) begin
            chk(g == last_w, last_req, "bypass group (R4 bit order)", g, last_w);
            run_len = 0;
            return;
        end
        ones = $countones(g);
        o6   = $countones(g[5:0]);
        o4   = $countones(g[9:6]);
        chk(rd ? (ones inside {4, 5}) : (ones inside {5, 6}), "R8", "group weight vs disparity",
            ones, rd ? 4 : 6);
        chk(o6 >= 2 && o6 <= 4 && o4 >= 1 && o4 <= 3, "R7", "sub-block weight", g, 0);
        maxr = 0;
        for (int b = 0; b < 10; b++) begin
            if (run_len > 0 && g[b] == run_bit) run_len++;
            else begin
                run_bit = g[b];
                run_len = 1;
            end
            if (run_len > maxr) maxr = run_len;
        end
        chk(maxr <= 5, "R7", "run length", maxr, 5);
        if (last_k) key = k_ok(last_w[7:0]) ? 256 + int'(last_w[7:0]) : 256 + 'hBC;
        else        key = int'(last_w[7:0]);
        if (owner[g] == -1) owner[g] = key;
        else chk(owner[g] == key, "R12", "group uniqueness", owner[g], key);
        if (last_k && (last_w[7:0] == 8'hBC || !k_ok(last_w[7:0]))) begin
            exp_g = rd ? lit(10'b1100000101) : lit(10'b0011111010);
            chk(g == exp_g, k_ok(last_w[7:0]) ? "R9" : "R10", "K28.5 group", g, exp_g);
        end else if (!last_k && last_w[7:0] == 8'h00) begin
            exp_g = rd ? lit(10'b0110001011) : lit(10'b1001110100);
            chk(g == exp_g, "R7", "D0.0 group", g, exp_g);
        end else if (!last_k && last_w[7:0] == 8'hB5) begin
            exp_g = lit(10'b1010101010);
            chk(g == exp_g, "R7", "D21.5 group", g, exp_g);
        end
        if (ones > 5) rd = 1'b1;
        else if (ones < 5) rd = 1'b0;
    endtask

    task automatic push(input logic [9:0] w, input bit k, input bit pin, input bit regb,
                        input bit glitch, input string req);
        logic [9:0] g;
        xfer(w, k, pin, regb, glitch, g);
        eval_prev(g);
        if ((pin | regb) && k && !k_ok(w[7:0])) exp_kerr = 1'b1;
        chk(k_err == exp_kerr, (pin | regb) ? "R10" : "R6", "k_err", k_err, exp_kerr);
        last_valid = 1'b1;
        last_w     = w;
        last_k     = k;
        last_en    = pin | regb;
        last_req   = req;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) owner[i] = -1;
        repeat (3) @(negedge clk);
        chk(ser_out == 1'b0 && word_clk == 1'b1 && k_err == 1'b0, "R1", "reset outputs",
            {ser_out, word_clk, k_err}, 3'b010);
        rst_n = 1'b1;
        chk(ser_out == 1'b0 && word_clk == 1'b1 && k_err == 1'b0, "R1", "after reset outputs",
            {ser_out, word_clk, k_err}, 3'b010);

        // R3 R4 R6: bypass groups, K ignored
        push(10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        push(10'h000, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        push(10'h2AA, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        push(10'h155, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 10; i++) push(10'(1 << i), 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        push(10'h01F, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        push(10'h3E0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");

        // R7 R8 R12: full byte sweep, pin enable, bypass words interleaved (R6)
        for (int b = 0; b < 256; b++) begin
            push(10'(b), 1'b0, 1'b1, 1'b0, 1'b0, "R7");
            if (b % 64 == 63) push(10'h3C3, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        end
        // R5: register enable alone, then both
        for (int b = 255; b >= 0; b--) push(10'(b) | 10'h300, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
        push(10'h0B5, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
        push(10'h000, 1'b0, 1'b1, 1'b1, 1'b0, "R5");

        // R9: all valid special codes, twice so both disparities appear
        for (int r = 0; r < 2; r++) begin
            foreach (owner[i]) if (i < 0) owner[i] = -1;
            for (int b = 0; b < 256; b++)
                if (k_ok(8'(b))) push(10'(b), 1'b1, 1'b1, 1'b0, 1'b0, "R9");
            push(10'h0F1, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        end

        // R6: invalid special request in bypass leaves k_err low
        push(10'h000, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        push(10'h03D, 1'b1, 1'b0, 1'b0, 1'b0, "R6");

        // R10: invalid special request while encoding
        push(10'h000, 1'b1, 1'b1, 1'b0, 1'b0, "R10");
        push(10'h0A3, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        push(10'h03D, 1'b1, 1'b0, 1'b1, 1'b0, "R10");
        push(10'h0BC, 1'b1, 1'b1, 1'b0, 1'b0, "R10");

        // R11: mode and K inputs toggled during the high phase of word_clk
        push(10'h0B5, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
        push(10'h0BC, 1'b1, 1'b0, 1'b1, 1'b1, "R11");
        push(10'h2D4, 1'b0, 1'b0, 1'b0, 1'b1, "R11");
        push(10'h1B3, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
        push(10'h000, 1'b0, 1'b1, 1'b0, 1'b1, "R11");

        // flush the last group
        push(10'h000, 1'b0, 1'b0, 1'b0, 1'b0, "R4");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule